// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target Model

This block is a synthesizable behavioural model of a serial EEPROM target. It holds a 64-word by 16-bit array in flip-flops. A host talks to it over a select line, a serial clock and a data-in line. The serial data output has a separate output-enable, so a pad or a shared wire can be built around it. All three serial inputs are sampled by a fast system clock through two-flop synchronizers, and edges on them are detected in the system clock domain. Every reaction at the output therefore appears a fixed three system clocks after the input change that caused it.

A command opens with a start bit, which is the first serial-clock rise seen with select and data-in both high. A two-bit opcode and a six-bit address follow, both shifted in MSB first. Reads stream data out at once, and they carry on into the following words for as long as select stays high.

Programming commands are write, erase, fill-erase and fill-write. They take effect only while the write-unlock latch is set. Each one starts a self-timed busy period on the falling edge of select. While that period runs, a host that raises select sees the busy/ready state on the data output.

Top module: `tw_eeprom`

## Requirements
- R1: A command starts only at the first serial-clock rise where select and data-in are both high; any number of rises with data-in low before that leave the block idle.
- R2: After the start bit, eight bits are shifted in MSB first: opcode[1:0] then address[5:0]. Opcode 10 reads, 01 writes a word, 11 erases a word to 16'hFFFF, and 00 selects a special command from address[5:4].
- R3: Special commands by address[5:4]: 11 sets the write-unlock latch, 00 clears it, 10 erases every word to 16'hFFFF, and 01 takes 16 data bits and writes them to every word.
- R4: A read first drives a single 0 on the output (output-enable high) after the last address bit, then the 16 data bits MSB first, one per serial-clock rise.
- R5: While select stays high, a read continues with the next address after bit 0 of each word, wrapping from address 63 to address 0.
- R6: After reset the write-unlock latch is clear; word writes, erases and both fill commands then change no word and start no busy period. Reads work whether the latch is set or clear.
- R7: A programming command runs on the falling edge of select only if all of its bits were clocked in (9 clocks, or 25 for word write and fill-write); a command cut short by select going low changes nothing.
- R8: When select is raised during or after a programming cycle, the output is enabled and drives 0 while busy and 1 once ready. The busy period lasts T_WORD, T_FERASE or T_FWRITE system clocks.
- R9: Select low returns the command logic to idle and disables the output.
- R10: Once a command has all of its bits, further serial clocks and data-in values are ignored until select goes low.
- R11: A start bit is ignored while a programming cycle is busy.
- R12: After reset every word reads 16'hFFFF and the output is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_sel_i | input | 1 | Serial select, high while a host is addressing the block |
| ser_clk_i | input | 1 | Serial clock; bits are taken on its rising edge |
| ser_din_i | input | 1 | Serial data in |
| ser_dout_o | output | 1 | Serial data out: read data or busy/ready state |
| ser_dout_oe_o | output | 1 | Output-enable for ser_dout_o |

## Verification
The main function is tried with single-word reads after reset, after word writes and after erases, and with a three-word streamed read that crosses from address 63 to 0. Together these show whether data, the leading dummy zero and the address step line up bit for bit. Programming is tried locked and unlocked, with its bits complete and cut short, and with extra clocks after completion. This tells apart the latch gating, the completeness rule and the ignore-after-done rule, since in each case the word read back differs. Status polls made just after select falls, during a busy period and after it ends separate the busy and ready levels. A read command sent while busy must leave the busy level on the output, which tells an ignored start from a started read.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_READ,
    ST_DONE
  } tw_state_e;

  localparam logic [1:0] OP_SPECIAL = 2'b00;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_ERASE   = 2'b11;

  localparam logic [1:0] SUB_LOCK   = 2'b00;
  localparam logic [1:0] SUB_FWRITE = 2'b01;
  localparam logic [1:0] SUB_FERASE = 2'b10;
  localparam logic [1:0] SUB_UNLOCK = 2'b11;

  typedef struct packed {
    logic valid;
    logic all;
    logic erase;
  } tw_prog_t;

endpackage

// File: rtl/tw_front.sv
module tw_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic sclk_i,
  input  logic din_i,
  output logic sel_s_o,
  output logic din_s_o,
  output logic sclk_rise_o,
  output logic sel_rise_o,
  output logic sel_fall_o
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] raw_w;
  logic [NSIG-1:0] stage_q [SYNC_STAGES];
  logic [NSIG-1:0] sync_w;
  logic [NSIG-1:0] prev_q;

  assign raw_w = {sel_i, sclk_i, din_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= raw_w;
      for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
      prev_q <= sync_w;
    end
  end

  assign sync_w      = stage_q[SYNC_STAGES-1];
  assign sel_s_o     = sync_w[2];
  assign din_s_o     = sync_w[0];
  assign sclk_rise_o = sync_w[1] & ~prev_q[1];
  assign sel_rise_o  = sync_w[2] & ~prev_q[2];
  assign sel_fall_o  = ~sync_w[2] & prev_q[2];

endmodule

// File: rtl/tw_timer.sv
module tw_timer #(
  parameter int unsigned T_WORD   = 2000,
  parameter int unsigned T_FERASE = 4000,
  parameter int unsigned T_FWRITE = 6000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic all_i,
  input  logic erase_i,
  output logic busy_o
);
  localparam int unsigned TMAX1 = (T_WORD > T_FERASE) ? T_WORD : T_FERASE;
  localparam int unsigned TMAX  = (TMAX1 > T_FWRITE) ? TMAX1 : T_FWRITE;
  localparam int CW = $clog2(TMAX + 1);

  logic [CW-1:0] cnt_q, cnt_d, load_w;

  always_comb begin
    if (all_i) load_w = erase_i ? CW'(T_FERASE) : CW'(T_FWRITE);
    else       load_w = CW'(T_WORD);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)             cnt_d = load_w;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/tw_array.sv
module tw_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_all_i,
  input  logic          wr_erase_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] wval_w;
  logic [DW-1:0] rd_vec [DEPTH];

  assign wval_w = wr_erase_i ? {DW{1'b1}} : wr_data_i;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic          hit_w;
    logic [DW-1:0] word_q;
    assign hit_w = wr_en_i & (wr_all_i | (wr_addr_i == AW'(g)));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    word_q <= {DW{1'b1}};
      else if (hit_w) word_q <= wval_w;
    end
    assign rd_vec[g] = word_q;
  end

  assign rd_data_o = rd_vec[rd_addr_i];

endmodule

// File: rtl/tw_eeprom.sv
module tw_eeprom #(
  parameter int          AW          = 6,
  parameter int          DW          = 16,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned T_WORD      = 2000,
  parameter int unsigned T_FERASE    = 4000,
  parameter int unsigned T_FWRITE    = 6000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ser_sel_i,
  input  logic ser_clk_i,
  input  logic ser_din_i,
  output logic ser_dout_o,
  output logic ser_dout_oe_o
);
  import tw_pkg::*;

  localparam int CMD_BITS = 2 + AW;
  localparam int CNT_MAX  = (CMD_BITS > DW) ? CMD_BITS : DW;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int RC_W     = $clog2(DW);

  logic sel_s, din_s, sclk_rise, sel_rise, sel_fall;
  logic busy, prog_start, rd_active, in_idle;

  tw_state_e          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CMD_BITS-1:0] sh_q, sh_d;
  logic [DW-1:0]      dsh_q, dsh_d;
  logic [AW-1:0]      addr_q, addr_d;
  tw_prog_t           pend_q, pend_d;
  logic               unlock_q, unlock_d;
  logic               armed_q, armed_d;
  logic               show_q, show_d;
  logic               rbit_q, rbit_d;
  logic [RC_W-1:0]    rcnt_q, rcnt_d;

  logic [CMD_BITS-1:0] cmd_full;
  logic [1:0]          op_w, sub_w;
  logic [AW-1:0]       caddr_w;
  logic [DW-1:0]       rd_data;
  logic [RC_W-1:0]     rd_idx;

  tw_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (ser_sel_i),
    .sclk_i      (ser_clk_i),
    .din_i       (ser_din_i),
    .sel_s_o     (sel_s),
    .din_s_o     (din_s),
    .sclk_rise_o (sclk_rise),
    .sel_rise_o  (sel_rise),
    .sel_fall_o  (sel_fall)
  );

  tw_timer #(.T_WORD(T_WORD), .T_FERASE(T_FERASE), .T_FWRITE(T_FWRITE)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (prog_start),
    .all_i   (pend_q.all),
    .erase_i (pend_q.erase),
    .busy_o  (busy)
  );

  tw_array #(.AW(AW), .DW(DW)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (prog_start),
    .wr_all_i   (pend_q.all),
    .wr_erase_i (pend_q.erase),
    .wr_addr_i  (addr_q),
    .wr_data_i  (dsh_q),
    .rd_addr_i  (addr_q),
    .rd_data_o  (rd_data)
  );

  assign cmd_full = {sh_q[CMD_BITS-2:0], din_s};
  assign op_w     = cmd_full[CMD_BITS-1 -: 2];
  assign caddr_w  = cmd_full[AW-1:0];
  assign sub_w    = caddr_w[AW-1 -: 2];
  assign rd_idx   = RC_W'(DW - 1) - rcnt_q;

  assign rd_active  = (state_q == ST_READ);
  assign in_idle    = (state_q == ST_IDLE);
  assign prog_start = sel_fall & (state_q == ST_DONE) & pend_q.valid & unlock_q & ~busy;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    dsh_d    = dsh_q;
    addr_d   = addr_q;
    pend_d   = pend_q;
    unlock_d = unlock_q;
    armed_d  = armed_q;
    show_d   = show_q;
    rbit_d   = rbit_q;
    rcnt_d   = rcnt_q;

    if (!sel_s) begin
      state_d      = ST_IDLE;
      pend_d.valid = 1'b0;
      show_d       = 1'b0;
    end else begin
      if (sel_rise && armed_q) show_d = 1'b1;
      if (sclk_rise) begin
        unique case (state_q)
          ST_IDLE: begin
            if (din_s && !busy) begin
              state_d = ST_CMD;
              cnt_d   = '0;
              show_d  = 1'b0;
              armed_d = 1'b0;
            end
          end
          ST_CMD: begin
            sh_d  = cmd_full;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(CMD_BITS - 1)) begin
              addr_d = caddr_w;
              cnt_d  = '0;
              unique case (op_w)
                OP_READ: begin
                  state_d = ST_READ;
                  rbit_d  = 1'b0;
                  rcnt_d  = '0;
                end
                OP_WRITE: begin
                  state_d = ST_DATA;
                  pend_d  = '{valid: 1'b0, all: 1'b0, erase: 1'b0};
                end
                OP_ERASE: begin
                  state_d = ST_DONE;
                  pend_d  = '{valid: 1'b1, all: 1'b0, erase: 1'b1};
                end
                default: begin
                  unique case (sub_w)
                    SUB_UNLOCK: begin state_d = ST_DONE; unlock_d = 1'b1; end
                    SUB_LOCK:   begin state_d = ST_DONE; unlock_d = 1'b0; end
                    SUB_FERASE: begin
                      state_d = ST_DONE;
                      pend_d  = '{valid: 1'b1, all: 1'b1, erase: 1'b1};
                    end
                    default: begin
                      state_d = ST_DATA;
                      pend_d  = '{valid: 1'b0, all: 1'b1, erase: 1'b0};
                    end
                  endcase
                end
              endcase
            end
          end
          ST_DATA: begin
            dsh_d = {dsh_q[DW-2:0], din_s};
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(DW - 1)) begin
              state_d      = ST_DONE;
              pend_d.valid = 1'b1;
            end
          end
          ST_READ: begin
            rbit_d = rd_data[rd_idx];
            if (rcnt_q == RC_W'(DW - 1)) begin
              rcnt_d = '0;
              addr_d = addr_q + 1'b1;
            end else begin
              rcnt_d = rcnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end

    if (prog_start) armed_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      dsh_q    <= '0;
      addr_q   <= '0;
      pend_q   <= '0;
      unlock_q <= 1'b0;
      armed_q  <= 1'b0;
      show_q   <= 1'b0;
      rbit_q   <= 1'b0;
      rcnt_q   <= '0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      dsh_q    <= dsh_d;
      addr_q   <= addr_d;
      pend_q   <= pend_d;
      unlock_q <= unlock_d;
      armed_q  <= armed_d;
      show_q   <= show_d;
      rbit_q   <= rbit_d;
      rcnt_q   <= rcnt_d;
    end
  end

  assign ser_dout_oe_o = rd_active | show_q;
  assign ser_dout_o    = rd_active ? rbit_q : (show_q & ~busy);

endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
  parameter int AW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sel_s,
  input logic          sel_fall,
  input logic          busy,
  input logic          unlock_q,
  input logic          rd_active,
  input logic          in_idle,
  input logic [AW-1:0] rd_addr,
  input logic          dout,
  input logic          dout_oe
);

  // R9: select low at the core leaves the output disabled on the next cycle
  a_r9_oe_off_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_s |=> !dout_oe);

  // R7: a busy period only begins right after a select falling edge
  a_r7_prog_on_sel_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(sel_fall));

  // R6: no busy period begins while the write-unlock latch is clear
  a_r6_prog_needs_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(unlock_q));

  // R4: entering a read drives the enabled dummy zero
  a_r4_dummy_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_active) |-> (dout_oe && !dout));

  // R11: the idle command logic stays idle while programming is busy
  a_r11_no_start_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && in_idle) |=> in_idle);

  // R5: within a streamed read the address only steps by one, wrapping
  a_r5_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_active && $past(rd_active) && (rd_addr != $past(rd_addr)))
      |-> (rd_addr == AW'($past(rd_addr) + 1'b1)));

endmodule

bind tw_eeprom tw_checker #(.AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_s     (sel_s),
  .sel_fall  (sel_fall),
  .busy      (busy),
  .unlock_q  (unlock_q),
  .rd_active (rd_active),
  .in_idle   (in_idle),
  .rd_addr   (addr_q),
  .dout      (ser_dout_o),
  .dout_oe   (ser_dout_oe_o)
);

// File: tb/sim_tw_eeprom.sv
module sim_tw_eeprom;
  localparam int TW  = 300;
  localparam int TFE = 500;
  localparam int TFW = 700;
  localparam int LAT = 3;
  localparam int H   = 4;

  localparam int S_IDLE = 0, S_CMD = 1, S_DATA = 2, S_READ = 3, S_DONE = 4;

  logic clk, rst_n;
  logic b_cs, b_sck, b_di;
  logic dout, dout_oe;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  tw_eeprom #(.T_WORD(TW), .T_FERASE(TFE), .T_FWRITE(TFW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ser_sel_i(b_cs), .ser_clk_i(b_sck),
    .ser_din_i(b_di), .ser_dout_o(dout), .ser_dout_oe_o(dout_oe)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int mem [64];
  int m_st, m_cnt, m_sh, m_dsh, m_addr, m_bcnt, m_rcnt;
  bit m_pend, m_pall, m_perase, m_we, m_armed, m_show, m_rbit;
  bit pcs, psck;
  bit h_oe [LAT];
  bit h_do [LAT];
  bit h_rd [LAT];

  task automatic model_reset();
    for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
    m_st = S_IDLE; m_cnt = 0; m_sh = 0; m_dsh = 0; m_addr = 0; m_bcnt = 0; m_rcnt = 0;
    m_pend = 0; m_pall = 0; m_perase = 0; m_we = 0; m_armed = 0; m_show = 0; m_rbit = 0;
    pcs = 0; psck = 0;
    for (int i = 0; i < LAT; i++) begin h_oe[i] = 0; h_do[i] = 0; h_rd[i] = 0; end
  endtask

  task automatic model_step(output bit eoe, output bit edo);
    bit pb, rise, cfall, crise;
    int full, op, a;
    pb = (m_bcnt != 0);
    if (m_bcnt != 0) m_bcnt--;
    rise  = b_sck && !psck;
    cfall = !b_cs && pcs;
    crise = b_cs && !pcs;
    if (!b_cs) begin
      if (cfall && m_st == S_DONE && m_pend && m_we && !pb) begin
        for (int i = 0; i < 64; i++)
          if (m_pall || i == m_addr) mem[i] = m_perase ? 16'hFFFF : m_dsh;
        m_bcnt  = m_pall ? (m_perase ? TFE : TFW) : TW;
        m_armed = 1;
      end
      m_st = S_IDLE; m_pend = 0; m_show = 0;
    end else begin
      if (crise && m_armed) m_show = 1;
      if (rise) begin
        case (m_st)
          S_IDLE: if (b_di && !pb) begin
            m_st = S_CMD; m_cnt = 0; m_show = 0; m_armed = 0;
          end
          S_CMD: begin
            m_sh = ((m_sh << 1) | b_di) & 8'hFF;
            m_cnt++;
            if (m_cnt == 8) begin
              full = m_sh; op = full >> 6; a = full & 63; m_addr = a; m_cnt = 0;
              if (op == 2) begin m_st = S_READ; m_rbit = 0; m_rcnt = 0; end
              else if (op == 1) begin m_st = S_DATA; m_pall = 0; m_perase = 0; end
              else if (op == 3) begin m_st = S_DONE; m_pend = 1; m_pall = 0; m_perase = 1; end
              else begin
                case (a >> 4)
                  3: begin m_st = S_DONE; m_we = 1; end
                  0: begin m_st = S_DONE; m_we = 0; end
                  2: begin m_st = S_DONE; m_pend = 1; m_pall = 1; m_perase = 1; end
                  default: begin m_st = S_DATA; m_pall = 1; m_perase = 0; end
                endcase
              end
            end
          end
          S_DATA: begin
            m_dsh = ((m_dsh << 1) | b_di) & 16'hFFFF;
            m_cnt++;
            if (m_cnt == 16) begin m_st = S_DONE; m_pend = 1; end
          end
          S_READ: begin
            m_rbit = (mem[m_addr] >> (15 - m_rcnt)) & 1;
            m_rcnt++;
            if (m_rcnt == 16) begin m_rcnt = 0; m_addr = (m_addr + 1) % 64; end
          end
          default: ;
        endcase
      end
    end
    psck = b_sck; pcs = b_cs;
    eoe = (m_st == S_READ) || m_show;
    edo = (m_st == S_READ) ? m_rbit : (m_show && m_bcnt == 0);
  endtask

  // per-clock comparison against the model delayed by the synchronizer latency
  always @(negedge clk) begin
    bit eoe, edo;
    #1;
    if (!rst_n) model_reset();
    else if (!done) begin
      n_cmp++;
      if (dout_oe !== h_oe[LAT-1] || (h_oe[LAT-1] && dout !== h_do[LAT-1])) begin
        n_bad++;
        $display("FAIL %s per-clock: actual oe=%0b do=%0b expected oe=%0b do=%0b at %0t",
                 h_rd[LAT-1] ? "R4 R5 read stream" : (h_oe[LAT-1] ? "R8 status" : "R9 idle"),
                 dout_oe, dout, h_oe[LAT-1], h_do[LAT-1], $time);
      end
      model_step(eoe, edo);
      for (int i = LAT - 1; i > 0; i--) begin
        h_oe[i] = h_oe[i-1]; h_do[i] = h_do[i-1]; h_rd[i] = h_rd[i-1];
      end
      h_oe[0] = eoe; h_do[0] = edo; h_rd[0] = (m_st == S_READ);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pins(input logic c, input logic s, input logic d);
    b_cs = c; b_sck = s; b_di = d;
    repeat (H) @(negedge clk);
  endtask

  task automatic sbit(input logic d);
    pins(1, 0, d);
    pins(1, 1, d);
  endtask

  task automatic sbits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sbit(v[i]);
  endtask

  task automatic cs_off();
    pins(1, 0, 0);
    pins(0, 0, 0);
    pins(0, 0, 0);
  endtask

  task automatic cmd(input logic [1:0] op, input logic [5:0] a);
    sbit(1);
    sbits({14'd0, op}, 2);
    sbits({10'd0, a}, 6);
  endtask

  task automatic write_word(input logic [5:0] a, input logic [15:0] d);
    cmd(2'b01, a); sbits(d, 16); cs_off();
  endtask

  task automatic wait_ready(input string tag);
    int guard;
    pins(1, 0, 0);
    guard = 0;
    while (!(dout_oe && dout) && guard < 5000) begin @(negedge clk); guard++; end
    chk(tag, {dout_oe, dout}, 2'b11);
    pins(0, 0, 0);
  endtask

  task automatic rd_chk(input string tag, input int pre, input logic [5:0] a, input int n,
                        input logic [15:0] e0, input logic [15:0] e1, input logic [15:0] e2);
    logic [15:0] w;
    logic [15:0] exp_w;
    pins(1, 0, 0);
    for (int i = 0; i < pre; i++) sbit(0);
    cmd(2'b10, a);
    chk("R4 dummy zero", {dout_oe, dout}, 2'b10);
    for (int k = 0; k < n; k++) begin
      w = '0;
      for (int b = 0; b < 16; b++) begin sbit(0); w = {w[14:0], dout}; end
      exp_w = (k == 0) ? e0 : ((k == 1) ? e1 : e2);
      chk(tag, w, exp_w);
    end
    cs_off();
    chk("R9 output off after select low", dout_oe, 0);
  endtask

  // ---------------- test sequence ----------------
  initial begin
    b_cs = 0; b_sck = 0; b_di = 0; rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R12 output disabled after reset", dout_oe, 0);
    rd_chk("R12 reset word", 0, 6'd3, 1, 16'hFFFF, 0, 0);

    // R6: locked after reset, write has no effect, no busy
    write_word(6'd5, 16'h1234);
    pins(1, 0, 0);
    chk("R6 no status when locked", dout_oe, 0);
    pins(0, 0, 0);
    rd_chk("R6 locked write ignored", 0, 6'd5, 1, 16'hFFFF, 0, 0);

    // R1 + R3: leading zero clocks, then unlock
    pins(1, 0, 0);
    sbits(16'h0, 4);
    cmd(2'b00, 6'b110000);
    cs_off();

    // R7/R8/R11: word write, busy status, start ignored while busy
    write_word(6'd5, 16'hA5C3);
    pins(1, 0, 0);
    chk("R8 busy level", {dout_oe, dout}, 2'b10);
    cmd(2'b10, 6'd5);
    sbit(0); sbit(0);
    chk("R11 read ignored while busy", {dout_oe, dout}, 2'b10);
    pins(0, 0, 0);
    wait_ready("R8 ready level");
    rd_chk("R7 word write", 0, 6'd5, 1, 16'hA5C3, 0, 0);
    rd_chk("R1 start after idle zero clocks", 5, 6'd5, 1, 16'hA5C3, 0, 0);

    // R10: extra clocks after a complete write are ignored
    cmd(2'b01, 6'd6); sbits(16'h1357, 16);
    sbit(1); sbit(1); sbit(0); sbit(1);
    cs_off();
    wait_ready("R8 ready after write");
    rd_chk("R10 extra clocks ignored", 0, 6'd6, 1, 16'h1357, 0, 0);

    // R7: incomplete write discarded
    cmd(2'b01, 6'd7); sbits(16'h02AA, 10);
    cs_off();
    pins(1, 0, 0);
    chk("R7 short command starts nothing", dout_oe, 0);
    pins(0, 0, 0);
    rd_chk("R7 short command no change", 0, 6'd7, 1, 16'hFFFF, 0, 0);

    // R2: erase word
    cmd(2'b11, 6'd5); cs_off();
    wait_ready("R8 ready after erase");
    rd_chk("R2 erase word", 0, 6'd5, 1, 16'hFFFF, 0, 0);

    // R3: fill-write, then R5 streamed read across the wrap
    cmd(2'b00, 6'b010000); sbits(16'h0F0F, 16); cs_off();
    wait_ready("R8 ready after fill-write");
    write_word(6'd63, 16'hBEEF); wait_ready("R8 ready");
    write_word(6'd0, 16'h0001);  wait_ready("R8 ready");
    rd_chk("R3 fill-write", 0, 6'd20, 1, 16'h0F0F, 0, 0);
    rd_chk("R5 stream wrap", 0, 6'd62, 3, 16'h0F0F, 16'hBEEF, 16'h0001);

    // R3: fill-erase
    cmd(2'b00, 6'b100000); cs_off();
    wait_ready("R8 ready after fill-erase");
    rd_chk("R3 fill-erase", 0, 6'd20, 1, 16'hFFFF, 0, 0);

    // R6: lock again, write ignored, read still works
    cmd(2'b00, 6'b000000); cs_off();
    write_word(6'd10, 16'h0000);
    pins(1, 0, 0);
    chk("R6 no status after lock", dout_oe, 0);
    pins(0, 0, 0);
    rd_chk("R6 read while locked", 0, 6'd10, 1, 16'hFFFF, 0, 0);

    repeat (8) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule